// File: doc/BRIEF.md
# Nested-Level Barrier Network Using a Maximum Tree

This block gives a group of processor ports hardware barriers that can be nested. It uses one shared integer reduction tree. Each port owns an agent that tracks how deeply the port is nested in conditionals and loops. The agent holds a small level counter and accepts four commands: enter a nesting, leave a nesting, arrive at a barrier, and finish the program. The agent drives an n-bit value into a pipelined binary tree whose nodes keep the larger of their two inputs. The tree's root is fanned back out through a pipelined broadcast tree to every port.

A port that is running code offers the all-ones value. This keeps every barrier closed. A port waiting at a barrier offers its nesting level. A port that has finished offers zero, so it never holds anyone back. The root therefore falls to a level L only when no port is still running and no port is waiting deeper than L. The innermost pending barrier always opens first, and only the ports waiting at exactly that level are released.

One tree can distinguish up to 2^n - 1 nesting levels at the same time, in place of one single-bit tree per level. Each agent must keep its barrier value on the tree for a programmable minimum number of cycles before it may be released. This stops a stale root value that is still travelling through the pipeline from releasing it.

Top module: `nested_barrier`

## Requirements
- R1: Every port's `glob_o` equals the maximum of all ports' `local_o` values as they were exactly 2*ceil(log2 NPORTS) cycles earlier, and all ports see the same `glob_o`.
- R2: After reset, and whenever a port is running (not waiting and not finished), its `local_o` is all ones.
- R3: The level counter resets to 0. Command code 2'b00 (enter) adds one, and command code 2'b01 (leave) subtracts one. The level is visible on `local_o` while the port waits at a barrier.
- R4: An enter command at level 2^LVL_W - 2 leaves the level unchanged. A leave command at level 0 leaves the level unchanged.
- R5: Command code 2'b10 (arrive) puts the port into the waiting state, with `local_o` equal to its level. The port stays waiting for as long as `glob_o` differs from that level.
- R6: Command code 2'b11 (finish) drives `local_o` to 0 for good. All later commands to that port are ignored, and the port never holds back a barrier of the other ports.
- R7: A waiting port is not released before it has waited HOLD_CYC cycles, even if `glob_o` already shows its level.
- R8: On release, `go_o` of the port is high for exactly one cycle, and `local_o` is back to all ones in that same cycle. Commands given while a port waits are ignored.
- R9: When ports wait at different levels, only the ports at the deepest waiting level are released. Release happens max(HOLD_CYC, 2*ceil(log2 NPORTS)) + 1 clock edges after the last arrival that completes the barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | NPORTS | Per-port command strobe |
| cmd_op | input | 2*NPORTS | Per-port command code: 00 enter, 01 leave, 10 arrive, 11 finish |
| local_o | output | NPORTS*LVL_W | Value each agent drives into the tree |
| glob_o | output | NPORTS*LVL_W | Broadcast root value delivered to each port |
| go_o | output | NPORTS | One-cycle release strobe per port |

## Verification
The bench builds the block with four ports, a 3-bit level, and HOLD_CYC equal to the 4-cycle round trip. With a 3-bit level, the saturation at level 6 can be reached in a handful of commands. With four ports, a mix of waiting levels can be set up, and it shows which ports the deepest barrier picks. Because HOLD_CYC equals the round trip exactly, release lands on a single predictable cycle. A port can also re-arrive in the window where the old root value is still draining from the pipeline, which exercises the hold rule.

// File: rtl/nb_pkg.sv
package nb_pkg;

  typedef enum logic [1:0] {
    OP_ENTER  = 2'b00,
    OP_LEAVE  = 2'b01,
    OP_ARRIVE = 2'b10,
    OP_FINISH = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_WAIT = 2'b01,
    ST_DONE = 2'b10
  } agent_st_e;

  // node count of a tree level that is `l` halvings above `n` leaves
  function automatic int level_size(input int n, input int l);
    return (n + (1 << l) - 1) >> l;
  endfunction

endpackage

// File: rtl/nb_agent.sv
module nb_agent #(
  parameter int LVL_W    = 4,
  parameter int HOLD_CYC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [1:0]       cmd_op,
  input  logic [LVL_W-1:0] glob_i,
  output logic [LVL_W-1:0] local_o,
  output logic             go_o
);
  import nb_pkg::*;

  localparam int CNT_W = $clog2(HOLD_CYC + 1) + 1;
  localparam logic [LVL_W-1:0] ONES    = '1;
  localparam logic [LVL_W-1:0] LVL_TOP = ONES - 1'b1;

  function automatic logic [LVL_W-1:0] lvl_up(input logic [LVL_W-1:0] l);
    return (l >= LVL_TOP) ? l : l + 1'b1;
  endfunction

  function automatic logic [LVL_W-1:0] lvl_down(input logic [LVL_W-1:0] l);
    return (l == '0) ? l : l - 1'b1;
  endfunction

  agent_st_e        st;
  logic [LVL_W-1:0] lvl;
  logic [CNT_W-1:0] hold_cnt;

  // named events
  logic running, do_enter, do_leave, do_arrive, do_finish, hold_done, release_ok;
  op_e  op;

  assign op         = op_e'(cmd_op);
  assign running    = (st == ST_RUN);
  assign do_enter   = running && cmd_vld && (op == OP_ENTER);
  assign do_leave   = running && cmd_vld && (op == OP_LEAVE);
  assign do_arrive  = running && cmd_vld && (op == OP_ARRIVE);
  assign do_finish  = running && cmd_vld && (op == OP_FINISH);
  assign hold_done  = (hold_cnt >= CNT_W'(HOLD_CYC));
  assign release_ok = (st == ST_WAIT) && hold_done && (glob_i == lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      lvl      <= '0;
      hold_cnt <= '0;
      go_o     <= 1'b0;
    end else begin
      go_o <= release_ok;
      if (do_enter)  lvl <= lvl_up(lvl);
      if (do_leave)  lvl <= lvl_down(lvl);
      if (do_arrive) begin
        st       <= ST_WAIT;
        hold_cnt <= '0;
      end
      if (do_finish) st <= ST_DONE;
      if (st == ST_WAIT && !hold_done) hold_cnt <= hold_cnt + 1'b1;
      if (release_ok) st <= ST_RUN;
    end
  end

  always_comb begin
    unique case (st)
      ST_WAIT: local_o = lvl;
      ST_DONE: local_o = '0;
      default: local_o = ONES;
    endcase
  end

  p_go_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> !go_o);

  p_go_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> (local_o == ONES));

  p_go_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> ($past(st) == ST_WAIT) && ($past(glob_i) == $past(lvl)));

  p_hold_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> ($past(hold_cnt) >= CNT_W'(HOLD_CYC)));

  p_lvl_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl != ONES);

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |=> (st == ST_DONE) && (local_o == '0));

endmodule

// File: rtl/nb_max_tree.sv
module nb_max_tree #(
  parameter int NPORTS = 8,
  parameter int LVL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORTS*LVL_W-1:0] leaf_i,
  output logic [LVL_W-1:0]        root_o
);
  import nb_pkg::*;

  localparam int DEPTH = $clog2(NPORTS);

  function automatic logic [LVL_W-1:0] max2(input logic [LVL_W-1:0] a,
                                            input logic [LVL_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  for (genvar l = 0; l <= DEPTH; l++) begin : g_t
    localparam int SZ = level_size(NPORTS, l);
    logic [SZ*LVL_W-1:0] nd;
    if (l == 0) begin : g_leaf
      assign nd = leaf_i;
    end else begin : g_reg
      localparam int PSZ = level_size(NPORTS, l - 1);
      logic [SZ*LVL_W-1:0] nxt;
      for (genvar i = 0; i < SZ; i++) begin : g_node
        if (2*i + 1 < PSZ) begin : g_pair
          assign nxt[i*LVL_W +: LVL_W] = max2(g_t[l-1].nd[2*i*LVL_W +: LVL_W],
                                              g_t[l-1].nd[(2*i+1)*LVL_W +: LVL_W]);
        end else begin : g_pass
          assign nxt[i*LVL_W +: LVL_W] = g_t[l-1].nd[2*i*LVL_W +: LVL_W];
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n) nd <= '1;
        else        nd <= nxt;
      end
    end
  end

  assign root_o = g_t[DEPTH].nd;

endmodule

// File: rtl/nb_bcast.sv
module nb_bcast #(
  parameter int NPORTS = 8,
  parameter int LVL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LVL_W-1:0]        root_i,
  output logic [NPORTS*LVL_W-1:0] leaf_o
);
  import nb_pkg::*;

  localparam int DEPTH = $clog2(NPORTS);

  for (genvar k = 0; k <= DEPTH; k++) begin : g_b
    localparam int SZ = level_size(NPORTS, DEPTH - k);
    logic [SZ*LVL_W-1:0] nd;
    if (k == 0) begin : g_top
      assign nd = root_i;
    end else begin : g_reg
      logic [SZ*LVL_W-1:0] nxt;
      for (genvar i = 0; i < SZ; i++) begin : g_node
        assign nxt[i*LVL_W +: LVL_W] = g_b[k-1].nd[(i/2)*LVL_W +: LVL_W];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) nd <= '1;
        else        nd <= nxt;
      end
    end
  end

  assign leaf_o = g_b[DEPTH].nd;

endmodule

// File: rtl/nested_barrier.sv
module nested_barrier #(
  parameter int NPORTS   = 8,
  parameter int LVL_W    = 4,
  parameter int HOLD_CYC = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORTS-1:0]       cmd_vld,
  input  logic [2*NPORTS-1:0]     cmd_op,
  output logic [NPORTS*LVL_W-1:0] local_o,
  output logic [NPORTS*LVL_W-1:0] glob_o,
  output logic [NPORTS-1:0]       go_o
);
  localparam int DEPTH     = $clog2(NPORTS);
  localparam int ROUNDTRIP = 2 * DEPTH;

  logic [LVL_W-1:0] root;

  initial begin
    a_cfg_r7: assert (NPORTS >= 2 && HOLD_CYC >= ROUNDTRIP)
      else $error("hold time shorter than round trip");
  end

  nb_max_tree #(.NPORTS(NPORTS), .LVL_W(LVL_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .leaf_i(local_o), .root_o(root));

  nb_bcast #(.NPORTS(NPORTS), .LVL_W(LVL_W)) u_bcast (
    .clk(clk), .rst_n(rst_n), .root_i(root), .leaf_o(glob_o));

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    nb_agent #(.LVL_W(LVL_W), .HOLD_CYC(HOLD_CYC)) u_agent (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_vld (cmd_vld[p]),
      .cmd_op  (cmd_op[2*p +: 2]),
      .glob_i  (glob_o[p*LVL_W +: LVL_W]),
      .local_o (local_o[p*LVL_W +: LVL_W]),
      .go_o    (go_o[p]));

    if (p > 0) begin : g_uni
      p_glob_uniform_r1: assert property (@(posedge clk) disable iff (!rst_n)
        glob_o[p*LVL_W +: LVL_W] == glob_o[LVL_W-1:0]);
    end
  end

endmodule

// File: tb/nested_barrier_tb.sv
module nested_barrier_tb;
  localparam int P = 4;
  localparam int W = 3;
  localparam int HOLD = 4;
  localparam int D = 2;
  localparam int LAT = ((HOLD > 2*D) ? HOLD : 2*D) + 1;
  localparam logic [1:0] ENT = 2'b00, LEV = 2'b01, ARR = 2'b10, FIN = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0]   cmd_vld = '0;
  logic [2*P-1:0] cmd_op = '0;
  logic [P*W-1:0] local_o, glob_o;
  logic [P-1:0]   go_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nested_barrier #(.NPORTS(P), .LVL_W(W), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .local_o(local_o), .glob_o(glob_o), .go_o(go_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int loc(input int p);
    return int'(local_o[p*W +: W]);
  endfunction

  task automatic do_cmd(input logic [P-1:0] mask, input logic [1:0] op);
    @(negedge clk);
    cmd_vld = mask;
    for (int p = 0; p < P; p++) cmd_op[2*p +: 2] = op;
    @(negedge clk);
    cmd_vld = '0;
  endtask

  task automatic wait_go(input int maxc, output logic [P-1:0] m, output int cyc);
    m = '0; cyc = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (go_o != '0) begin
        m = go_o; cyc = i;
        break;
      end
    end
  endtask

  task automatic chk_glob_all(input string req, input int exp);
    for (int p = 0; p < P; p++) chk(req, int'(glob_o[p*W +: W]), exp);
  endtask

  task automatic t_reset;
    for (int p = 0; p < P; p++) chk("R2 reset local", loc(p), 7);
    chk("R8 reset go", int'(go_o), 0);
    chk_glob_all("R1 reset glob", 7);
  endtask

  task automatic t_common_barrier;
    logic [P-1:0] m; int c;
    do_cmd(4'b0001, ENT); do_cmd(4'b0001, ENT); do_cmd(4'b0001, ARR);
    chk("R3 level after two enters", loc(0), 2);
    wait_go(15, m, c);
    chk("R5 blocked while others run", int'(m), 0);
    chk("R5 still waiting", loc(0), 2);
    do_cmd(4'b1110, ENT); do_cmd(4'b1110, ENT); do_cmd(4'b1110, ARR);
    wait_go(20, m, c);
    chk("R9 release mask all", int'(m), 15);
    chk("R9 release latency", c, LAT);
    for (int p = 0; p < P; p++) chk("R8 local ones at go", loc(p), 7);
    @(negedge clk);
    chk("R8 go one cycle", int'(go_o), 0);
  endtask

  task automatic t_mixed_levels;
    logic [P-1:0] m; int c;
    do_cmd(4'b0001, ENT); do_cmd(4'b1010, LEV);   // levels 3,1,2,1
    do_cmd(4'b1111, ARR);
    repeat (4) @(negedge clk);
    chk_glob_all("R1 glob is max", 3);
    wait_go(20, m, c);
    chk("R9 deepest only", int'(m), 1);
    chk("R9 deepest latency", c, 1);
    do_cmd(4'b0001, LEV); do_cmd(4'b0001, ARR);
    wait_go(20, m, c);
    chk("R9 level2 pair", int'(m), 5);
    chk("R9 level2 latency", c, LAT);
    do_cmd(4'b0101, LEV); do_cmd(4'b0101, ARR);
    wait_go(20, m, c);
    chk("R9 outer all", int'(m), 15);
  endtask

  task automatic t_hold;
    logic [P-1:0] m; int c;
    @(negedge clk);
    chk("R8 go dropped", int'(go_o), 0);
    do_cmd(4'b0001, ARR);            // re-arrive while stale level 1 drains
    wait_go(20, m, c);
    chk("R7 no release on stale glob", int'(m), 0);
    chk("R5 local at level", loc(0), 1);
    do_cmd(4'b1110, ARR);
    wait_go(20, m, c);
    chk("R7 later release", int'(m), 15);
    chk("R7 release latency", c, LAT);
  endtask

  task automatic t_saturate_finish;
    logic [P-1:0] m; int c;
    for (int i = 0; i < 6; i++) do_cmd(4'b0001, ENT);
    do_cmd(4'b0001, ARR);
    chk("R4 enter saturates", loc(0), 6);
    do_cmd(4'b0001, ENT);
    chk("R8 command ignored while waiting", loc(0), 6);
    do_cmd(4'b1110, FIN);
    for (int p = 1; p < P; p++) chk("R6 finished local zero", loc(p), 0);
    wait_go(20, m, c);
    chk("R6 finished do not block", int'(m), 1);
    chk("R6 release latency", c, LAT);
    do_cmd(4'b0010, ENT); do_cmd(4'b0010, ARR);
    chk("R6 commands after finish ignored", loc(1), 0);
    for (int i = 0; i < 7; i++) do_cmd(4'b0001, LEV);
    do_cmd(4'b0001, ARR);
    chk("R4 leave floors at zero", loc(0), 0);
    wait_go(20, m, c);
    chk("R5 level0 release", int'(m), 1);
    do_cmd(4'b0001, FIN);
    repeat (5) @(negedge clk);
    chk_glob_all("R1 glob all finished", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_common_barrier;
    t_mixed_levels;
    t_hold;
    t_saturate_finish;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule